// File: doc/BRIEF.md
# Lane Power and Precharge Sequencer

This block powers the four lanes of a serial display link up and down in a fixed order. A command arrives as a single-cycle `start` pulse. It carries a lane count, a direction flag and a mode flag that selects a low-voltage differential signalling (LVDS) timing or a normal link timing. The block turns the count into a cumulative lane set. It then visits every lane slot one at a time. Between any two slots it waits a step delay that depends on the mode.

A power-up visit switches each lane in the set on and forces every lane outside the set off. The visits run from lane 0 upward. After the last visit the block drives a common-mode precharge pulse on the enabled lanes for a fixed number of microseconds and then clears it. A power-down visit switches off the lanes outside the set and leaves the lanes inside it as they were. These visits run from lane 3 downward and produce no precharge.

All timing is counted in microseconds. The block derives one microsecond from a clock divider that restarts at every command. A programmable bound aborts a command that runs too long. `done` and `error` are levels that stay set until the next command is taken.

Top module: `lane_pwr_seq`

## Requirements
- R1: A lane count of 1 selects lane 0, 2 selects lanes 0 and 1, and 4 selects lanes 0 to 3. Bit i of `lane_on` and of `precharge` belongs to lane i.
- R2: A `start` with any other lane count sets `error`, leaves `busy` low and leaves `lane_on` and `precharge` unchanged.
- R3: At the end of a power-up, lanes outside the set are off. A power-down switches off the lanes outside the set and keeps the state of the lanes inside it.
- R4: Power-up visits lanes in ascending order (0,1,2,3). Power-down visits them in descending order (3,2,1,0).
- R5: One microsecond is CLK_DIV clocks. Each lane visit takes a step delay of 15 µs in LVDS mode and 1 µs otherwise, so a lane changes only on a multiple of that delay after `start`. A power-down ends 4 step delays after `start`. A power-up ends 4 step delays plus PRECHARGE_US after `start`.
- R6: After the power-up visits, `precharge` equals the lane set for exactly PRECHARGE_US microseconds and then returns to zero. A power-down never raises `precharge`.
- R7: `busy` is high from the clock after an accepted `start` until the command ends. `done` rises when the command completes normally. `done` and `error` are cleared by the next `start` taken while idle.
- R8: If `timeout_us` is nonzero and the command has not completed when the elapsed microsecond count reaches it, the command stops with `error` set, `done` clear and `precharge` cleared. Any lanes already visited keep their state. A value of 0 turns the bound off.
- R9: A `start` that arrives while `busy` is high is ignored and does not change the command in progress.
- R10: After reset, `lane_on`, `precharge`, `busy`, `done` and `error` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, one cycle |
| power_up | input | 1 | 1 = power-up command, 0 = power-down command |
| lvds_mode | input | 1 | 1 = 15 µs step delay, 0 = 1 µs step delay |
| lane_count | input | CNT_W (3) | Requested lane count (1, 2 or 4 are valid) |
| timeout_us | input | TMO_W (16) | Abort bound in microseconds, 0 = no bound |
| lane_on | output | LANES (4) | Per-lane power enable, 1 = lane powered |
| precharge | output | LANES (4) | Per-lane common-mode precharge |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command completed normally |
| error | output | 1 | Last command rejected or timed out |

## Verification
Every result is counted in whole clocks from the rising edge that samples `start`. `busy`, `done` and the `error` of a rejected command appear one edge later. Lane visit k lands k·S·CLK_DIV edges after `start`. The precharge pulse begins on the edge of the last visit and lasts PRECHARGE_US·CLK_DIV edges. A timeout lands timeout_us·CLK_DIV edges after `start`. The bench drives inputs and samples outputs on falling edges. It counts the falling edges since the `start` edge, so lane changes, pulse length and end time can each be compared with those exact counts and not with a window.

// File: rtl/lps_pkg.sv
// Package: shared state encoding for the lane power sequencer.
// Assumes: nothing beyond the standard language.
package lps_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STEP  = 2'd1,
        SEQ_PRECH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lps_us_tick.sv
// Microsecond tick generator: pulses tick once every CLK_DIV clocks.
// The count restarts on restart, so a command's timing is exact from its start.
// Assumes: CLK_DIV >= 2.
module lps_us_tick #(
    parameter int CLK_DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] div_cnt;

    // Tick on the last count of each microsecond.
    assign tick = (div_cnt == CW'(CLK_DIV - 1));

    // Divider counter with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end

    // R5: ticks are isolated single-cycle pulses.
    a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/lps_lane_decode.sv
// Lane set decoder: turns a lane count into a cumulative lane mask.
// Valid counts are nonzero powers of two up to LANES. Any other count
// gives an empty mask and valid low.
// Assumes: LANES fits in CNT_W bits.
module lps_lane_decode #(
    parameter int LANES = 4,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] lane_count,
    output logic [LANES-1:0] mask,
    output logic             valid
);
    // Count check: a nonzero power of two, no larger than the lane total.
    always_comb begin
        valid = (lane_count != '0)
             && ((lane_count & (lane_count - CNT_W'(1))) == '0)
             && (lane_count <= CNT_W'(LANES));
    end

    // One compare per lane: lane i is in the set when i < count.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = valid && (lane_count > CNT_W'(i));
    end
endmodule

// File: rtl/lps_step_ctrl.sv
// Step controller: takes commands, visits lanes one step delay apart,
// runs the precharge pulse after a power-up and enforces the timeout.
// Assumes: tick is a one-cycle pulse per microsecond and restarts on restart.
// Step delays and PRECHARGE_US are at least 1.
module lps_step_ctrl
    import lps_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int TMO_W        = 16,
    parameter int DP_STEP_US   = 1,
    parameter int LVDS_STEP_US = 15,
    parameter int PRECHARGE_US = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             power_up,
    input  logic             lvds_mode,
    input  logic [LANES-1:0] mask_in,
    input  logic             mask_valid,
    input  logic [TMO_W-1:0] timeout_us,
    output logic             restart,
    output logic [LANES-1:0] lane_on,
    output logic [LANES-1:0] precharge,
    output logic             busy,
    output logic             done,
    output logic             error
);
    localparam int IDX_W   = (LANES > 2) ? $clog2(LANES) : 1;
    localparam int MAX_STP = (LVDS_STEP_US > DP_STEP_US) ? LVDS_STEP_US : DP_STEP_US;
    localparam int MAX_W8  = (PRECHARGE_US > MAX_STP) ? PRECHARGE_US : MAX_STP;
    localparam int WAIT_W  = $clog2(MAX_W8 + 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [WAIT_W-1:0] wait_cnt;
    logic [WAIT_W-1:0] step_q;
    logic [TMO_W-1:0]  elapsed;
    logic [LANES-1:0]  mask_q;
    logic              dir_up;
    logic              step_last;
    logic              wait_hit;
    logic              complete_now;
    logic              tmo_hit;

    assign busy    = (state != SEQ_IDLE);
    assign restart = start && !busy;

    // Last slot in the current direction.
    assign step_last = dir_up ? (idx == IDX_W'(LANES - 1)) : (idx == '0);

    // Wait expires on this tick.
    assign wait_hit = tick && (wait_cnt == WAIT_W'(1));

    // Normal completion happens on this edge.
    assign complete_now = wait_hit && (((state == SEQ_STEP) && step_last && !dir_up)
                                       || (state == SEQ_PRECH));

    // Timeout bound reached on this tick without completing.
    assign tmo_hit = busy && tick && (timeout_us != '0)
                  && ((elapsed + TMO_W'(1)) == timeout_us) && !complete_now;

    // Command sequencing: accept, lane visits, precharge and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            idx       <= '0;
            wait_cnt  <= '0;
            step_q    <= '0;
            elapsed   <= '0;
            mask_q    <= '0;
            dir_up    <= 1'b0;
            lane_on   <= '0;
            precharge <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
        end else if (state == SEQ_IDLE) begin
            if (start) begin
                done  <= 1'b0;
                error <= !mask_valid;
                if (mask_valid) begin
                    state    <= SEQ_STEP;
                    dir_up   <= power_up;
                    mask_q   <= mask_in;
                    idx      <= power_up ? '0 : IDX_W'(LANES - 1);
                    elapsed  <= '0;
                    step_q   <= lvds_mode ? WAIT_W'(LVDS_STEP_US) : WAIT_W'(DP_STEP_US);
                    wait_cnt <= lvds_mode ? WAIT_W'(LVDS_STEP_US) : WAIT_W'(DP_STEP_US);
                end
            end
        end else if (tmo_hit) begin
            state     <= SEQ_IDLE;
            error     <= 1'b1;
            precharge <= '0;
        end else if (tick) begin
            elapsed <= elapsed + TMO_W'(1);
            if (wait_cnt != WAIT_W'(1)) begin
                wait_cnt <= wait_cnt - WAIT_W'(1);
            end else if (state == SEQ_STEP) begin
                if (dir_up) begin
                    lane_on[idx] <= mask_q[idx];
                end else begin
                    lane_on[idx] <= lane_on[idx] & mask_q[idx];
                end
                if (step_last) begin
                    if (dir_up) begin
                        state     <= SEQ_PRECH;
                        precharge <= mask_q;
                        wait_cnt  <= WAIT_W'(PRECHARGE_US);
                    end else begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end
                end else begin
                    idx      <= dir_up ? idx + IDX_W'(1) : idx - IDX_W'(1);
                    wait_cnt <= step_q;
                end
            end else begin
                precharge <= '0;
                state     <= SEQ_IDLE;
                done      <= 1'b1;
            end
        end
    end

    // R1: every accepted set contains lane 0.
    a_r1_lane0_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mask_valid) |=> mask_q[0]);

    // R2: a rejected count flags an error and touches no lane.
    a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mask_valid) |=> (!busy && error && $stable(lane_on)));

    // R3: a power-down never switches a lane on.
    a_r3_down_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dir_up) |=> ((lane_on & ~$past(lane_on)) == '0));

    // R6: precharge only on powered lanes, only during a command.
    a_r6_precharge_on_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (precharge != '0) |-> (((precharge & ~lane_on) == '0) && busy));

    // R7: done never overlaps a running command.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: an error leaves the block idle with precharge off.
    a_r8_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!busy && (precharge == '0)));

    // R9: a start during a command leaves the latched command alone.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dir_up) && $stable(mask_q)));
endmodule

// File: rtl/lane_pwr_seq.sv
// Lane power and precharge sequencer, top level.
// Connects the microsecond tick, the lane set decoder and the step controller.
// Assumes: start is a one-cycle strobe in the clk domain and CLK_DIV >= 2.
module lane_pwr_seq #(
    parameter int LANES        = 4,
    parameter int CNT_W        = 3,
    parameter int TMO_W        = 16,
    parameter int CLK_DIV      = 200,
    parameter int DP_STEP_US   = 1,
    parameter int LVDS_STEP_US = 15,
    parameter int PRECHARGE_US = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             power_up,
    input  logic             lvds_mode,
    input  logic [CNT_W-1:0] lane_count,
    input  logic [TMO_W-1:0] timeout_us,
    output logic [LANES-1:0] lane_on,
    output logic [LANES-1:0] precharge,
    output logic             busy,
    output logic             done,
    output logic             error
);
    logic             tick;
    logic             restart;
    logic [LANES-1:0] set_mask;
    logic             set_valid;

    lps_us_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    lps_lane_decode #(.LANES(LANES), .CNT_W(CNT_W)) u_decode (
        .lane_count (lane_count),
        .mask       (set_mask),
        .valid      (set_valid)
    );

    lps_step_ctrl #(
        .LANES        (LANES),
        .TMO_W        (TMO_W),
        .DP_STEP_US   (DP_STEP_US),
        .LVDS_STEP_US (LVDS_STEP_US),
        .PRECHARGE_US (PRECHARGE_US)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (start),
        .power_up   (power_up),
        .lvds_mode  (lvds_mode),
        .mask_in    (set_mask),
        .mask_valid (set_valid),
        .timeout_us (timeout_us),
        .restart    (restart),
        .lane_on    (lane_on),
        .precharge  (precharge),
        .busy       (busy),
        .done       (done),
        .error      (error)
    );
endmodule

// File: tb/tb_lane_pwr_seq.sv
module tb_lane_pwr_seq;
    localparam int DIV = 4;
    localparam int PRE = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        power_up = 1'b0;
    logic        lvds_mode = 1'b0;
    logic [2:0]  lane_count = 3'd0;
    logic [15:0] timeout_us = 16'd1000;
    logic [3:0]  lane_on;
    logic [3:0]  precharge;
    logic        busy;
    logic        done;
    logic        error;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lane_pwr_seq #(.CLK_DIV(DIV), .PRECHARGE_US(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .power_up(power_up),
        .lvds_mode(lvds_mode), .lane_count(lane_count), .timeout_us(timeout_us),
        .lane_on(lane_on), .precharge(precharge), .busy(busy),
        .done(done), .error(error)
    );

    // Vector: {power_up, lvds, count[3], accepted, final lanes[4], end cycle[12]}
    localparam int NV = 9;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd1, 1'b1, 4'b0001, 12'd416},
        {1'b1, 1'b0, 3'd4, 1'b1, 4'b1111, 12'd416},
        {1'b0, 1'b0, 3'd2, 1'b1, 4'b0011, 12'd16},
        {1'b0, 1'b1, 3'd1, 1'b1, 4'b0001, 12'd240},
        {1'b1, 1'b1, 3'd2, 1'b1, 4'b0011, 12'd640},
        {1'b1, 1'b0, 3'd3, 1'b0, 4'b0011, 12'd0},
        {1'b0, 1'b0, 3'd0, 1'b0, 4'b0011, 12'd0},
        {1'b1, 1'b0, 3'd4, 1'b1, 4'b1111, 12'd416},
        {1'b0, 1'b0, 3'd4, 1'b1, 4'b1111, 12'd16}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Launches one command and follows it to the end, checking timing and order.
    task automatic run_cmd(input bit pu, input bit lv, input logic [2:0] cnt,
                           input bit ok, input logic [3:0] exp_l, input int exp_t,
                           input bit inject);
        logic [3:0] prev;
        int n = 0;
        int pch = 0;
        int last;
        int sd;
        bit order_ok = 1'b1;
        bit step_ok = 1'b1;
        bit pch_ok = 1'b1;
        sd = (lv ? 15 : 1) * DIV;
        last = pu ? -1 : 4;
        @(negedge clk);
        prev = lane_on;
        power_up = pu; lvds_mode = lv; lane_count = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!ok) begin
            chk(!busy, "R2 busy stays low", busy, 0);
            chk(error && !done, "R2 error set", error, 1);
            chk(lane_on == prev, "R2 lanes unchanged", lane_on, prev);
            chk(precharge == 4'b0, "R2 precharge unchanged", precharge, 0);
            return;
        end
        chk(busy && !done && !error, "R7 busy after start", busy, 1);
        while (busy && n < 4000) begin
            if (inject && n == 10) begin
                start = 1'b1; power_up = 1'b0; lane_count = 3'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
            for (int i = 0; i < 4; i++) begin
                if (lane_on[i] != prev[i]) begin
                    if (pu ? (i <= last) : (i >= last)) order_ok = 1'b0;
                    last = i;
                    if (n % sd != 0) step_ok = 1'b0;
                end
            end
            if (precharge != 4'b0) begin
                pch++;
                if (precharge != exp_l) pch_ok = 1'b0;
            end
            prev = lane_on;
        end
        start = 1'b0;
        chk(n == exp_t, "R5 end cycle", n, exp_t);
        chk(lane_on == exp_l, "R1 R3 final lanes", lane_on, exp_l);
        chk(done && !error, "R7 done set", done, 1);
        chk(order_ok, "R4 visit order", order_ok, 1);
        chk(step_ok, "R5 step spacing", step_ok, 1);
        chk(pch == (pu ? PRE * DIV : 0), "R6 precharge length", pch, pu ? PRE * DIV : 0);
        chk(pch_ok, "R6 precharge lanes", pch_ok, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(lane_on == 4'b0 && precharge == 4'b0, "R10 outputs zero", lane_on, 0);
        chk(!busy && !done && !error, "R10 status zero", {busy, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_cmd(VEC[v][21], VEC[v][20], VEC[v][19:17], VEC[v][16],
                    VEC[v][15:12], int'(VEC[v][11:0]), 1'b0);
        end

        // R3 power-down to a single lane
        run_cmd(1'b0, 1'b0, 3'd1, 1'b1, 4'b0001, 16, 1'b0);

        // R8: timeout after 50 us during an LVDS power-up of four lanes
        begin
            int n = 0;
            bit pch_seen = 1'b0;
            timeout_us = 16'd50;
            @(negedge clk);
            power_up = 1'b1; lvds_mode = 1'b1; lane_count = 3'd4; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (busy && n < 4000) begin
                @(negedge clk);
                n++;
                if (precharge != 4'b0) pch_seen = 1'b1;
            end
            chk(n == 50 * DIV, "R8 abort cycle", n, 50 * DIV);
            chk(error && !done, "R8 error flag", error, 1);
            chk(lane_on == 4'b0111, "R8 visited lanes kept", lane_on, 4'b0111);
            chk(!pch_seen && precharge == 4'b0, "R8 no precharge", precharge, 0);
        end

        // R9: a start during a command is ignored (bound disabled with 0)
        timeout_us = 16'd0;
        run_cmd(1'b1, 1'b0, 3'd2, 1'b1, 4'b0011, 416, 1'b1);

        // R7: flags cleared by the next accepted start
        timeout_us = 16'd1000;
        @(negedge clk);
        power_up = 1'b0; lvds_mode = 1'b0; lane_count = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !error && busy, "R7 flags cleared on start", {done, error}, 0);
        repeat (20) @(negedge clk);
        chk(done && lane_on == 4'b0011, "R7 second command completes", lane_on, 4'b0011);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule